// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-local memory address into a rank-local address. It also reports which rank of the channel owns that address. A small configuration store holds four range descriptors and sixteen interleave descriptors. A start pulse launches a walk over the range descriptors, one per clock. When a range claims the address, the block removes the rank interleave from the address and picks the interleave descriptor for the address's way slot. It then subtracts that descriptor's base offset and returns the resulting address together with the channel rank. The channel rank is also split into a DIMM number and a rank within that DIMM.

The interleave granule depends on the page policy of the DIMM: closed-page parts interleave on 64-byte units and open-page parts on 8 KiB units. Range boundaries chain from one descriptor to the next. A descriptor that is switched off still moves the lower bound forward. An address that falls in no range, uses an unsupported way count, or sits below its offset ends with done raised and valid low.

Top module: `rank_ilv_decoder`

## Requirements
- R1: While reset is held, and after it is released, done, valid and err are low, and rank_addr and chan_rank are zero.
- R2: Range descriptors are examined one per clock starting from index 0. If descriptor k claims the address, done rises k+1 clocks after the clock edge that samples start. Done is high for exactly one cycle.
- R3: Range descriptor word layout: bit 31 enables the range, bits 11:1 give the upper bound as (field << 29) | 0x1FFFFFFF, and bits 29:28 give the way code. A descriptor claims the address when it is enabled and lower ≤ addr ≤ upper. The lower bound of descriptor 0 is zero. The lower bound of each later descriptor is the previous descriptor's upper bound, unchanged and whether or not that descriptor is enabled.
- R4: When no descriptor claims the address, done rises after all four have been examined, with valid and err low and the data outputs zero.
- R5: The interleave shift s is 6 when closed_page is 1 and 13 when it is 0.
- R6: With ways = 1 << way code, the compacted address is ((addr >> s) / ways) << s, ORed with addr's low s bits.
- R7: The way slot is (addr >> s) mod ways. The interleave descriptor used is number slot*4 + range index. A config write with cfg_is_ilv=1 stores descriptor cfg_idx; with cfg_is_ilv=0 it stores range descriptor cfg_idx[1:0].
- R8: Interleave descriptor word layout: bits 15:2 give an offset of field << 26, and bits 19:16 give the channel rank. Bits 31:20 and 1:0 are ignored. rank_addr is the compacted address minus the offset. dimm_num is chan_rank / 4 and rank_in_dimm is chan_rank mod 4.
- R9: If the offset exceeds the compacted address, the result is err=1 and valid=0 with zero data. An offset equal to the compacted address is legal and yields rank_addr 0.
- R10: A claiming range with way code 3 (eight ways, more than the four interleave slots) gives err=1 and valid=0.
- R11: A start pulse arriving while a walk is in progress is ignored. Address and page flag are captured only at an accepted start.
- R12: Results stay unchanged on the outputs from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_ilv | input | 1 | 1 selects an interleave descriptor, 0 a range descriptor |
| cfg_idx | input | 4 | Descriptor number for the write |
| cfg_wdata | input | 32 | Descriptor word |
| start | input | 1 | Launches a decode |
| chan_addr | input | 40 | Channel-local address |
| closed_page | input | 1 | 1 when the DIMM uses a closed-page policy |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Last decode succeeded |
| err | output | 1 | Last decode hit a range but could not be mapped |
| rank_addr | output | 40 | Rank-local address |
| chan_rank | output | 4 | Rank number within the channel |
| dimm_num | output | 2 | DIMM holding the rank |
| rank_in_dimm | output | 2 | Rank within that DIMM |

## Verification
Take the rising edge that samples start as edge N. A hit on descriptor k produces its result after edge N+k+1, and a miss produces its result after edge N+4. After reset is released, the block stays in reset for two more edges. The bench drives inputs just after a rising edge and samples outputs on the falling edge. It counts falling edges from the one at which start is seen and compares that count against the expected latency, which it derives from the descriptor index its own model finds. Between completions, every falling edge also confirms that done has fallen and the outputs have held their values.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int LIM_FIELD_W = 11;
  localparam int LIM_GRAN    = 29;
  localparam int OFF_FIELD_W = 14;
  localparam int OFF_GRAN    = 26;
  localparam int CR_W        = 4;

  typedef struct packed {
    logic                   vld;
    logic [1:0]             ways_code;
    logic [LIM_FIELD_W-1:0] lim;
  } range_cfg_t;

  typedef struct packed {
    logic [CR_W-1:0]        rank;
    logic [OFF_FIELD_W-1:0] off;
  } ilv_cfg_t;

  typedef enum logic {SCAN_IDLE, SCAN_RUN} scan_st_e;
endpackage

// File: rtl/rid_cfg_regs.sv
module rid_cfg_regs
  import rid_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int WAY_SLOTS  = 4,
  localparam int ILV_N     = NUM_RANGES * WAY_SLOTS,
  localparam int IDX_W     = $clog2(ILV_N),
  localparam int ENT_W     = $clog2(NUM_RANGES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic                        is_ilv,
  input  logic [IDX_W-1:0]            idx,
  input  logic [31:0]                 wdata,
  output range_cfg_t [NUM_RANGES-1:0] range_o,
  output ilv_cfg_t   [ILV_N-1:0]      ilv_o
);
  range_cfg_t range_q [NUM_RANGES];
  ilv_cfg_t   ilv_q   [ILV_N];

  logic unused_wdata;
  assign unused_wdata = ^{wdata[30], wdata[27:20], wdata[0]};

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    logic wr_en;
    assign wr_en = we && !is_ilv && (idx[ENT_W-1:0] == ENT_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     range_q[r] <= '0;
      else if (wr_en) range_q[r] <= '{vld: wdata[31], ways_code: wdata[29:28], lim: wdata[11:1]};
    end
  end

  for (genvar i = 0; i < ILV_N; i++) begin : g_ilv
    logic wr_en;
    assign wr_en = we && is_ilv && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ilv_q[i] <= '0;
      else if (wr_en) ilv_q[i] <= '{rank: wdata[19:16], off: wdata[15:2]};
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RANGES; r++) range_o[r] = range_q[r];
    for (int i = 0; i < ILV_N; i++)      ilv_o[i]   = ilv_q[i];
  end
endmodule

// File: rtl/rid_scan.sv
module rid_scan
  import rid_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int NUM_RANGES = 4,
  localparam int ENT_W     = $clog2(NUM_RANGES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        closed_i,
  input  range_cfg_t [NUM_RANGES-1:0] range_i,
  output logic                        fin_o,
  output logic                        hit_o,
  output logic [ENT_W-1:0]            ent_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        closed_o
);
  scan_st_e          state_q, state_d;
  logic [ENT_W-1:0]  ent_q, ent_d;
  logic [ADDR_W-1:0] prev_q, prev_d;
  logic [ADDR_W-1:0] addr_q;
  logic              closed_q;
  logic [ADDR_W-1:0] cur_lim;
  logic              load, last;

  assign load    = (state_q == SCAN_IDLE) && start;
  assign cur_lim = ADDR_W'({range_i[ent_q].lim, {LIM_GRAN{1'b1}}});
  assign last    = (ent_q == ENT_W'(NUM_RANGES - 1));
  assign hit_o   = (state_q == SCAN_RUN) && range_i[ent_q].vld &&
                   (prev_q <= addr_q) && (addr_q <= cur_lim);
  assign fin_o   = (state_q == SCAN_RUN) && (hit_o || last);
  assign ent_o   = ent_q;
  assign addr_o  = addr_q;
  assign closed_o = closed_q;

  always_comb begin
    state_d = state_q;
    ent_d   = ent_q;
    prev_d  = prev_q;
    if (load) begin
      state_d = SCAN_RUN;
      ent_d   = '0;
      prev_d  = '0;
    end else if (fin_o) begin
      state_d = SCAN_IDLE;
    end else if (state_q == SCAN_RUN) begin
      ent_d   = ent_q + ENT_W'(1);
      prev_d  = cur_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      ent_q   <= '0;
      prev_q  <= '0;
    end else begin
      state_q <= state_d;
      ent_q   <= ent_d;
      prev_q  <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      closed_q <= 1'b0;
    end else if (load) begin
      addr_q   <= addr_i;
      closed_q <= closed_i;
    end
  end

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN && !fin_o) |=> (state_q == SCAN_RUN && ent_q == $past(ent_q) + ENT_W'(1)));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN && !fin_o) |=> ($stable(addr_q) && $stable(closed_q)));
endmodule

// File: rtl/rid_calc.sv
module rid_calc
  import rid_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int NUM_RANGES = 4,
  parameter int WAY_SLOTS  = 4,
  parameter int SH_CLOSED  = 6,
  parameter int SH_OPEN    = 13,
  localparam int ILV_N     = NUM_RANGES * WAY_SLOTS,
  localparam int ENT_W     = $clog2(NUM_RANGES),
  localparam int WIDX_W    = $clog2(WAY_SLOTS)
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   closed_i,
  input  logic [1:0]             ways_code_i,
  input  logic [ENT_W-1:0]       ent_i,
  input  ilv_cfg_t [ILV_N-1:0]   ilv_i,
  output logic [ADDR_W-1:0]      rank_addr_o,
  output logic [CR_W-1:0]        chan_rank_o,
  output logic                   err_o
);
  logic [4:0]         sh;
  logic [ADDR_W-1:0]  shifted, low_mask, compact, offset;
  logic [WIDX_W-1:0]  widx, widx_mask;
  logic               bad_ways;
  ilv_cfg_t           sel;

  always_comb begin
    sh        = closed_i ? 5'(SH_CLOSED) : 5'(SH_OPEN);
    shifted   = addr_i >> sh;
    low_mask  = (ADDR_W'(1) << sh) - ADDR_W'(1);
    bad_ways  = (int'(ways_code_i) > WIDX_W);
    widx_mask = WIDX_W'((32'd1 << ways_code_i) - 32'd1);
    widx      = shifted[WIDX_W-1:0] & widx_mask;
    compact   = ((shifted >> ways_code_i) << sh) | (addr_i & low_mask);
    sel       = ilv_i[{widx, ent_i}];
    offset    = ADDR_W'(sel.off) << OFF_GRAN;
    err_o     = bad_ways || (offset > compact);
    rank_addr_o = compact - offset;
    chan_rank_o = sel.rank;
  end
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
  import rid_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int NUM_RANGES = 4,
  parameter int WAY_SLOTS  = 4,
  parameter int SH_CLOSED  = 6,
  parameter int SH_OPEN    = 13,
  localparam int ILV_N     = NUM_RANGES * WAY_SLOTS,
  localparam int IDX_W     = $clog2(ILV_N),
  localparam int ENT_W     = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_is_ilv,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic              closed_page,
  output logic              done,
  output logic              valid,
  output logic              err,
  output logic [ADDR_W-1:0] rank_addr,
  output logic [CR_W-1:0]   chan_rank,
  output logic [1:0]        dimm_num,
  output logic [1:0]        rank_in_dimm
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  range_cfg_t [NUM_RANGES-1:0] range_cfg;
  ilv_cfg_t   [ILV_N-1:0]      ilv_cfg;
  logic                        fin, hit, s_closed, c_err;
  logic [ENT_W-1:0]            s_ent;
  logic [ADDR_W-1:0]           s_addr, c_rank_addr;
  logic [CR_W-1:0]             c_cr;

  rid_cfg_regs #(.NUM_RANGES(NUM_RANGES), .WAY_SLOTS(WAY_SLOTS)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .is_ilv(cfg_is_ilv),
    .idx(cfg_idx), .wdata(cfg_wdata), .range_o(range_cfg), .ilv_o(ilv_cfg));

  rid_scan #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_scan (
    .clk(clk), .rst_n(rst_int_n), .start(start), .addr_i(chan_addr),
    .closed_i(closed_page), .range_i(range_cfg), .fin_o(fin), .hit_o(hit),
    .ent_o(s_ent), .addr_o(s_addr), .closed_o(s_closed));

  rid_calc #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .WAY_SLOTS(WAY_SLOTS),
             .SH_CLOSED(SH_CLOSED), .SH_OPEN(SH_OPEN)) u_calc (
    .addr_i(s_addr), .closed_i(s_closed), .ways_code_i(range_cfg[s_ent].ways_code),
    .ent_i(s_ent), .ilv_i(ilv_cfg), .rank_addr_o(c_rank_addr),
    .chan_rank_o(c_cr), .err_o(c_err));

  logic              done_q, done_d, valid_q, valid_d, err_q, err_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic [CR_W-1:0]   cr_q, cr_d;

  always_comb begin
    done_d  = fin;
    valid_d = valid_q;
    err_d   = err_q;
    ra_d    = ra_q;
    cr_d    = cr_q;
    if (fin) begin
      if (hit && !c_err) begin
        valid_d = 1'b1;
        err_d   = 1'b0;
        ra_d    = c_rank_addr;
        cr_d    = c_cr;
      end else begin
        valid_d = 1'b0;
        err_d   = hit;
        ra_d    = '0;
        cr_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      ra_q    <= '0;
      cr_q    <= '0;
    end else begin
      done_q  <= done_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      ra_q    <= ra_d;
      cr_q    <= cr_d;
    end
  end

  assign done         = done_q;
  assign valid        = valid_q;
  assign err          = err_q;
  assign rank_addr    = ra_q;
  assign chan_rank    = cr_q;
  assign dimm_num     = cr_q[CR_W-1:CR_W-2];
  assign rank_in_dimm = cr_q[1:0];

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R9
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(valid && err));

  // R4
  miss_result_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fin && !hit) |=> (done && !valid && !err && rank_addr == '0));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fin |=> ($stable(rank_addr) && $stable(valid) && $stable(err) && $stable(chan_rank)));
endmodule

// File: tb/tb_rank_ilv_decoder.sv
module tb_rank_ilv_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_is_ilv, start, closed_page;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [39:0] chan_addr;
  logic        done, valid, err;
  logic [39:0] rank_addr;
  logic [3:0]  chan_rank;
  logic [1:0]  dimm_num, rank_in_dimm;

  always #10 clk = ~clk;

  rank_ilv_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_ilv(cfg_is_ilv),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .start(start),
    .chan_addr(chan_addr), .closed_page(closed_page), .done(done),
    .valid(valid), .err(err), .rank_addr(rank_addr), .chan_rank(chan_rank),
    .dimm_num(dimm_num), .rank_in_dimm(rank_in_dimm));

  typedef struct {
    bit           vld;
    bit           er;
    longint       ra;
    int           cr;
    int           lat;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  bit       m_vld[4];
  int       m_code[4];
  longint   m_lim[4];
  int       m_cr[16];
  longint   m_off[16];

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(longint a, bit cp);
    exp_t   e;
    longint prev = 0, lim, q0, comp, off, ways;
    int     found = -1, n = 0, sh, wi, r;
    for (int i = 0; i < 4; i++) begin
      lim = (m_lim[i] << 29) | 64'h1FFFFFFF;
      n++;
      if (m_vld[i] && a >= prev && a <= lim) begin
        found = i;
        break;
      end
      prev = lim;
    end
    e.lat = n + 1;
    e.vld = 0; e.er = 0; e.ra = 0; e.cr = 0;
    if (found >= 0) begin
      if (m_code[found] == 3) e.er = 1;
      else begin
        sh   = cp ? 6 : 13;
        ways = 64'd1 << m_code[found];
        q0   = a >> sh;
        comp = (q0 / ways) * (64'd1 << sh) + (a % (64'd1 << sh));
        wi   = int'(q0 % ways);
        r    = wi * 4 + found;
        off  = m_off[r] * (64'd1 << 26);
        if (off > comp) e.er = 1;
        else begin
          e.vld = 1;
          e.ra  = comp - off;
          e.cr  = m_cr[r];
        end
      end
    end
    return e;
  endfunction

  task automatic wr(bit is_ilv, int idx, logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1; cfg_is_ilv = is_ilv; cfg_idx = 4'(idx); cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic cfg_range(int i, bit v, int code, int lim);
    m_vld[i] = v; m_code[i] = code; m_lim[i] = longint'(lim);
    wr(0, i, {v, 1'b0, 2'(code), 16'hA5A5, 11'(lim), 1'b1});
  endtask

  task automatic cfg_ilv(int i, int cr, int off);
    m_cr[i] = cr; m_off[i] = longint'(off);
    wr(1, i, {12'hABC, 4'(cr), 14'(off), 2'b11});
  endtask

  task automatic run(longint a, bit cp, string tag);
    exp_t e;
    e = model(a, cp);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk); #2;
    start = 1; chan_addr = 40'(a); closed_page = cp;
    @(posedge clk); #2;
    start = 0;
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
  endtask

  // R11: second start during a walk must be dropped
  task automatic run_busy(longint a, longint b);
    exp_t e;
    e = model(a, 1);
    e.tag = "R11";
    q.push_back(e);
    @(posedge clk); #2;
    start = 1; chan_addr = 40'(a); closed_page = 1;
    @(posedge clk); #2;
    start = 0; chan_addr = 40'(b); closed_page = 0;
    @(posedge clk); #2;
    start = 1;
    @(posedge clk); #2;
    start = 0;
    wait (q.size() == 0);
    repeat (8) @(posedge clk);
  endtask

  // monitor / scoreboard
  bit     armed = 0, prev_done = 0, have_last = 0;
  int     lat = 0;
  exp_t   last;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (armed) lat++;
      if (prev_done && done) chk(0, "R2", "done longer than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(lat == e.lat, "R2", {e.tag, " latency"}, lat, e.lat);
          chk(valid == e.vld, e.tag, "valid", valid, e.vld);
          chk(err == e.er, e.tag, "err", err, e.er);
          chk(rank_addr == 40'(e.ra), e.tag, "rank_addr", rank_addr, e.ra);
          chk(chan_rank == 4'(e.cr), "R8", {e.tag, " chan_rank"}, chan_rank, e.cr);
          chk({dimm_num, rank_in_dimm} == 4'(e.cr), "R8", "dimm/rank split",
              {dimm_num, rank_in_dimm}, e.cr);
          last = e;
          have_last = 1;
        end
        armed = 0;
      end else if (have_last) begin
        chk(valid == last.vld && err == last.er && rank_addr == 40'(last.ra) &&
            chan_rank == 4'(last.cr), "R12", "held result", rank_addr, last.ra);
      end
      if (start && !armed) begin
        armed = 1;
        lat = 0;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_is_ilv = 0; cfg_idx = 0; cfg_wdata = 0;
    start = 0; chan_addr = 0; closed_page = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(!done && !valid && !err, "R1", "flags in reset", {done, valid, err}, 0);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 after release
    chk(!done && !valid && !err, "R1", "flags after reset", {done, valid, err}, 0);
    chk(rank_addr == 0 && chan_rank == 0, "R1", "data after reset", rank_addr, 0);

    cfg_range(0, 1, 1, 2);
    cfg_range(1, 0, 0, 4);
    cfg_range(2, 1, 2, 8);
    cfg_range(3, 1, 3, 12);
    for (int i = 0; i < 16; i++) cfg_ilv(i, i ^ 5, i & 3);
    cfg_ilv(4, 9, 8);

    run(40'h0_4000_0000, 0, "R6");
    run(40'h0_4000_0040, 1, "R9");
    run(40'h0_5FFF_FFFF, 1, "R3");
    run(40'h0_9FFF_FFFF, 0, "R3");
    run(40'h0_7000_0000, 0, "R4");
    run(40'h0_0000_2000, 0, "R9");
    run(40'h1_0000_0040, 1, "R7");
    run(40'h1_0000_2000, 0, "R5");
    run(40'h1_0000_2000, 1, "R5");
    run(40'h1_5000_0000, 1, "R10");
    run(40'h1_A000_0000, 0, "R4");
    run(40'h0_0000_0000, 1, "R6");
    cfg_ilv(6, 3, 1);
    run(40'h1_0000_0040, 1, "R7");
    run_busy(40'h1_0000_0040, 40'h0_4000_0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule